// File: doc/BRIEF.md
# Exception entry and return sequencer

This block sits beside a processor's control unit and performs the state bookkeeping for taking an exception and for returning from one. On an entry request it takes a 6-bit exception code, a model select (classic or embedded), the next-instruction address and the current machine state word. From these it writes a save pair (saved address and saved status), forms the machine state the handler runs with, and looks up the handler address in a 64-entry vector table. On a return request it reads one of the two save pairs and produces the restored program counter and state word under a model-dependent mask.

Results appear one clock after the request, with a one-cycle acknowledge. The save registers are visible as outputs at all times. The vector table is loaded through a simple write port. Three conditions stop an entry without a vector. A machine check taken while machine checks are disabled puts the block into a sticky checkstop. A floating-point program exception that the current mode suppresses is discarded. An undefined vector-table entry raises an error pulse.

Top module: `exc_seq`

## Requirements
- R1: After reset, all save registers, `state_out` and `pc_out` read 0, `checkstop` is 0, and every vector-table entry is undefined (all ones), so an entry for any code that has not been loaded gives `vec_err`.
- R2: The saved status is `state_in` with the bits in 0x783F0000 cleared in the classic model (`model_emb`=0), and all of `state_in` in the embedded model.
- R3: For codes 2, 3, 5, 6 and 7 the saved address is `pc_in`-4. For every other code it is `pc_in`.
- R4: In the embedded model, codes 10 and 11 write the critical pair (`crit_pc`, `crit_st`). Every other entry writes the primary pair (`save_pc`, `save_st`), and the other pair keeps its value.
- R5: The new state keeps only bit 12 (machine-check enable) of `state_in`, with all other bits 0. Codes 0 (system reset) and 1 (machine check) clear bit 12 as well.
- R6: Code 1 with `state_in` bit 12 = 0 sets `checkstop`, which stays 1 until reset. No save register, `state_out` or `pc_out` changes.
- R7: `pc_out` after an entry is the table entry for the code ORed with `prefix`. An all-ones entry instead gives a one-cycle `vec_err` pulse with no register change.
- R8: When `alt_off` = 3 and `state_in` bits 5 and 4 are both 1, the vector is also ORed with 0xC000000000004000 and bits 5 and 4 are set in the new state. For any other `alt_off` value, or when either bit is 0, `alt_off` has no effect.
- R9: Code 6 with `prog_fp`=1 is discarded when `state_in` bits 11 and 8 are both 0, or when bit 13 is 0. A discard gives a one-cycle `discard` pulse with no register change.
- R10: On return, `pc_out` is the selected saved address (critical pair if `ret_crit`=1) with bits 1:0 forced to 0.
- R11: On return, the restored state is the saved status ANDed with the inverse of 0x783F0000 (classic) or with all ones (embedded). If bit 63 of that result is 0, the upper 32 bits are taken from `state_in` when `keep_high`=1 and are 0 otherwise.
- R12: `ack_entry` or `ack_ret` is high for exactly the one cycle after a request. When both requests arrive together, the entry is taken and the return is dropped.
- R13: While `checkstop` is 1, entry and return requests are ignored: there is no acknowledge and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Take an exception this cycle |
| exc_code | input | 6 | Exception code |
| model_emb | input | 1 | 1 = embedded model, 0 = classic |
| prog_fp | input | 1 | Program exception is of floating-point type |
| pc_in | input | 64 | Next-instruction address |
| state_in | input | 64 | Current machine state word |
| alt_off | input | 2 | Alternate vector offset field |
| prefix | input | 64 | Global vector prefix |
| ret_req | input | 1 | Return from interrupt this cycle |
| ret_crit | input | 1 | Return uses the critical pair |
| keep_high | input | 1 | Keep upper state half on a 32-bit return |
| vt_we | input | 1 | Vector table write enable |
| vt_addr | input | 6 | Vector table write index |
| vt_data | input | 64 | Vector table write data |
| ack_entry | output | 1 | Entry acknowledge pulse |
| ack_ret | output | 1 | Return acknowledge pulse |
| vec_err | output | 1 | Undefined vector pulse |
| discard | output | 1 | Suppressed floating-point exception pulse |
| checkstop | output | 1 | Sticky checkstop |
| pc_out | output | 64 | Handler vector or restored address |
| state_out | output | 64 | New or restored state word |
| save_pc | output | 64 | Primary saved address |
| save_st | output | 64 | Primary saved status |
| crit_pc | output | 64 | Critical saved address |
| crit_st | output | 64 | Critical saved status |

## Verification
A wrongly held save register shows up at the `save_*` or `crit_*` outputs on the very cycle after the entry that should have written it. It shows up again at `pc_out` and `state_out` on the cycle after the next return. A corrupted vector-table word or a missed alternate-offset decision appears in `pc_out` one cycle after the entry for that code, so every code is swept in both models under several state patterns. A checkstop flag that fails to hold is exposed on the next request, because an acknowledge appears where none is allowed.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
   localparam int CODE_W = 6;
   localparam int SW     = 64;

   localparam logic [CODE_W-1:0] C_RESET = 6'd0;
   localparam logic [CODE_W-1:0] C_MCHK  = 6'd1;
   localparam logic [CODE_W-1:0] C_DSTOR = 6'd2;
   localparam logic [CODE_W-1:0] C_ISTOR = 6'd3;
   localparam logic [CODE_W-1:0] C_ALIGN = 6'd5;
   localparam logic [CODE_W-1:0] C_PROG  = 6'd6;
   localparam logic [CODE_W-1:0] C_FPUN  = 6'd7;
   localparam logic [CODE_W-1:0] C_CRIT  = 6'd10;
   localparam logic [CODE_W-1:0] C_WDOG  = 6'd11;

   localparam int B_DT  = 4;
   localparam int B_IT  = 5;
   localparam int B_FE1 = 8;
   localparam int B_FE0 = 11;
   localparam int B_ME  = 12;
   localparam int B_FP  = 13;
   localparam int B_WIDE = 63;

   localparam logic [SW-1:0] RSVD_MASK = 64'h0000_0000_783F_0000;
   localparam logic [SW-1:0] ALT_VEC   = 64'hC000_0000_0000_4000;

   typedef struct packed {
      logic [SW-1:0] sv_pc;
      logic [SW-1:0] sv_st;
      logic [SW-1:0] nst;
      logic [SW-1:0] vec;
      logic          crit;
      logic          undef;
      logic          disc;
      logic          cstop;
   } entry_res_t;
endpackage

// File: rtl/exc_vtable.sv
module exc_vtable #(
   parameter int XLEN = 64,
   parameter int AW   = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [AW-1:0]   raddr,
   output logic [XLEN-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [XLEN-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
   import exc_seq_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter bit ALT_EN = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   input  logic              emb,
   input  logic              prog_fp,
   input  logic [XLEN-1:0]   pc,
   input  logic [XLEN-1:0]   st,
   input  logic [1:0]        alt,
   input  logic [XLEN-1:0]   prefix,
   input  logic [XLEN-1:0]   vt_word,
   output entry_res_t        res
);
   logic alt_hit;
   logic faulting;

   generate
      if (ALT_EN) begin : g_alt
         assign alt_hit = (alt == 2'b11) && st[B_IT] && st[B_DT];
      end else begin : g_noalt
         assign alt_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      faulting = (code == C_DSTOR) || (code == C_ISTOR) || (code == C_ALIGN) ||
                 (code == C_PROG)  || (code == C_FPUN);
      res.sv_st = emb ? st : (st & ~RSVD_MASK);
      res.sv_pc = faulting ? (pc - XLEN'(4)) : pc;
      res.crit  = emb && ((code == C_CRIT) || (code == C_WDOG));
      res.nst   = '0;
      if ((code != C_RESET) && (code != C_MCHK)) res.nst[B_ME] = st[B_ME];
      res.undef = &vt_word;
      res.vec   = vt_word | prefix;
      res.cstop = (code == C_MCHK) && !st[B_ME];
      res.disc  = (code == C_PROG) && prog_fp &&
                  ((!st[B_FE0] && !st[B_FE1]) || !st[B_FP]);
      if (alt_hit) begin
         res.vec      = res.vec | ALT_VEC;
         res.nst[B_IT] = 1'b1;
         res.nst[B_DT] = 1'b1;
      end
   end
endmodule

// File: rtl/exc_ret_calc.sv
module exc_ret_calc
   import exc_seq_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] s_pc,
   input  logic [XLEN-1:0] s_st,
   input  logic            emb,
   input  logic            keep_high,
   input  logic [XLEN-1:0] cur_st,
   output logic [XLEN-1:0] r_pc,
   output logic [XLEN-1:0] r_st
);
   localparam int HALF = XLEN / 2;

   logic [XLEN-1:0] masked;

   always_comb begin
      r_pc   = s_pc & ~XLEN'(3);
      masked = s_st & (emb ? {XLEN{1'b1}} : ~RSVD_MASK);
      if (masked[B_WIDE]) begin
         r_st = masked;
      end else begin
         r_st = {(keep_high ? cur_st[XLEN-1:HALF] : {HALF{1'b0}}), masked[HALF-1:0]};
      end
   end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_seq_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter bit ALT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              entry_req,
   input  logic [CODE_W-1:0] exc_code,
   input  logic              model_emb,
   input  logic              prog_fp,
   input  logic [XLEN-1:0]   pc_in,
   input  logic [XLEN-1:0]   state_in,
   input  logic [1:0]        alt_off,
   input  logic [XLEN-1:0]   prefix,
   input  logic              ret_req,
   input  logic              ret_crit,
   input  logic              keep_high,
   input  logic              vt_we,
   input  logic [CODE_W-1:0] vt_addr,
   input  logic [XLEN-1:0]   vt_data,
   output logic              ack_entry,
   output logic              ack_ret,
   output logic              vec_err,
   output logic              discard,
   output logic              checkstop,
   output logic [XLEN-1:0]   pc_out,
   output logic [XLEN-1:0]   state_out,
   output logic [XLEN-1:0]   save_pc,
   output logic [XLEN-1:0]   save_st,
   output logic [XLEN-1:0]   crit_pc,
   output logic [XLEN-1:0]   crit_st
);
   generate
      if (XLEN != SW) begin : g_bad_xlen
         $error("exc_seq: XLEN must equal the package state width");
      end
   endgenerate

   logic [XLEN-1:0] vt_word;
   entry_res_t      er;
   logic [XLEN-1:0] rpc, rst;

   exc_vtable #(.XLEN(XLEN), .AW(CODE_W)) u_vt (
      .clk(clk), .rst_n(rst_n), .we(vt_we), .waddr(vt_addr), .wdata(vt_data),
      .raddr(exc_code), .rdata(vt_word)
   );

   exc_entry_calc #(.XLEN(XLEN), .ALT_EN(ALT_EN)) u_ent (
      .code(exc_code), .emb(model_emb), .prog_fp(prog_fp), .pc(pc_in),
      .st(state_in), .alt(alt_off), .prefix(prefix), .vt_word(vt_word), .res(er)
   );

   exc_ret_calc #(.XLEN(XLEN)) u_ret (
      .s_pc(ret_crit ? crit_pc : save_pc), .s_st(ret_crit ? crit_st : save_st),
      .emb(model_emb), .keep_high(keep_high), .cur_st(state_in),
      .r_pc(rpc), .r_st(rst)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_entry <= 1'b0;
         ack_ret   <= 1'b0;
         vec_err   <= 1'b0;
         discard   <= 1'b0;
         checkstop <= 1'b0;
         pc_out    <= '0;
         state_out <= '0;
         save_pc   <= '0;
         save_st   <= '0;
         crit_pc   <= '0;
         crit_st   <= '0;
      end else begin
         ack_entry <= 1'b0;
         ack_ret   <= 1'b0;
         vec_err   <= 1'b0;
         discard   <= 1'b0;
         if (!checkstop) begin
            if (entry_req) begin
               ack_entry <= 1'b1;
               if (er.cstop) begin
                  checkstop <= 1'b1;
               end else if (er.disc) begin
                  discard <= 1'b1;
               end else if (er.undef) begin
                  vec_err <= 1'b1;
               end else begin
                  if (er.crit) begin
                     crit_pc <= er.sv_pc;
                     crit_st <= er.sv_st;
                  end else begin
                     save_pc <= er.sv_pc;
                     save_st <= er.sv_st;
                  end
                  state_out <= er.nst;
                  pc_out    <= er.vec;
               end
            end else if (ret_req) begin
               ack_ret   <= 1'b1;
               pc_out    <= rpc;
               state_out <= rst;
            end
         end
      end
   end

   // R6
   checkstop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      checkstop |=> checkstop);

   // R13
   checkstop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      checkstop |=> (!ack_entry && !ack_ret));

   // R10
   ret_pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_ret |-> (pc_out[1:0] == 2'b00));

   // R12
   ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_entry |-> !ack_ret);

   // R7
   vec_err_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_err |-> ($stable(save_pc) && $stable(save_st) && $stable(crit_pc) &&
                   $stable(crit_st) && $stable(state_out) && $stable(pc_out)));

   // R9
   discard_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      discard |-> ($stable(save_pc) && $stable(save_st) && $stable(crit_pc) &&
                   $stable(crit_st) && $stable(state_out) && $stable(pc_out)));
endmodule

// File: tb/tb_exc_seq.sv
module tb_exc_seq;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] PFX  = 64'h0000_0000_0F00_0000;
   localparam logic [63:0] RSV  = 64'h0000_0000_783F_0000;
   localparam logic [63:0] ALTV = 64'hC000_0000_0000_4000;

   logic        clk = 1'b0;
   logic        rst_n, entry_req, model_emb, prog_fp, ret_req, ret_crit, keep_high, vt_we;
   logic [5:0]  exc_code, vt_addr;
   logic [1:0]  alt_off;
   logic [63:0] pc_in, state_in, prefix, vt_data;
   logic        ack_entry, ack_ret, vec_err, discard, checkstop;
   logic [63:0] pc_out, state_out, save_pc, save_st, crit_pc, crit_st;

   int checks = 0;
   int errors = 0;
   logic [63:0] e_sp, e_ss, e_cp, e_cs, e_so, e_po;

   exc_seq dut (
      .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .exc_code(exc_code),
      .model_emb(model_emb), .prog_fp(prog_fp), .pc_in(pc_in), .state_in(state_in),
      .alt_off(alt_off), .prefix(prefix), .ret_req(ret_req), .ret_crit(ret_crit),
      .keep_high(keep_high), .vt_we(vt_we), .vt_addr(vt_addr), .vt_data(vt_data),
      .ack_entry(ack_entry), .ack_ret(ack_ret), .vec_err(vec_err), .discard(discard),
      .checkstop(checkstop), .pc_out(pc_out), .state_out(state_out),
      .save_pc(save_pc), .save_st(save_st), .crit_pc(crit_pc), .crit_st(crit_st)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_regs(input string tag);
      chk({tag, " save_pc"}, save_pc, e_sp);
      chk({tag, " save_st"}, save_st, e_ss);
      chk({tag, " crit_pc"}, crit_pc, e_cp);
      chk({tag, " crit_st"}, crit_st, e_cs);
      chk({tag, " state_out"}, state_out, e_so);
      chk({tag, " pc_out"}, pc_out, e_po);
   endtask

   task automatic go(input logic ent, input logic ret, input logic [5:0] code,
                     input logic emb, input logic fp, input logic [63:0] pc,
                     input logic [63:0] st, input logic [1:0] alt,
                     input logic rc, input logic kh);
      @(negedge clk);
      entry_req = ent; ret_req = ret; exc_code = code; model_emb = emb;
      prog_fp = fp; pc_in = pc; state_in = st; alt_off = alt;
      ret_crit = rc; keep_high = kh;
      @(negedge clk);
      entry_req = 1'b0; ret_req = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      e_sp = '0; e_ss = '0; e_cp = '0; e_cs = '0; e_so = '0; e_po = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] pats [3];
      logic [1:0]  alts [3];
      pats[0] = 64'hFFFF_FFFF_FFFF_FFFF; alts[0] = 2'd3;
      pats[1] = 64'h0000_0000_1234_1000; alts[1] = 2'd3;
      pats[2] = 64'h8000_0000_783F_1030; alts[2] = 2'd2;
      entry_req = 0; ret_req = 0; exc_code = 0; model_emb = 0; prog_fp = 0;
      pc_in = 0; state_in = 0; alt_off = 0; prefix = PFX; ret_crit = 0;
      keep_high = 0; vt_we = 0; vt_addr = 0; vt_data = 0; rst_n = 1'b0;
      do_reset();
      // R1 reset state
      chk_regs("R1 reset");
      chk("R1 checkstop", {63'd0, checkstop}, 64'd0);
      chk("R1 acks", {62'd0, ack_entry, ack_ret}, 64'd0);
      // R1 undefined table after reset
      go(1, 0, 6'd5, 0, 0, 64'h100, 64'h1000, 0, 0, 0);
      chk("R1 vec_err unloaded", {63'd0, vec_err}, 64'd1);
      chk_regs("R1 no write");
      // load table entries 0..62
      for (int i = 0; i < 63; i++) begin
         @(negedge clk);
         vt_we = 1'b1; vt_addr = 6'(i); vt_data = 64'(i) << 8;
      end
      @(negedge clk);
      vt_we = 1'b0;
      // sweep: R2 R3 R4 R5 R7 R8 R12
      for (int m = 0; m < 2; m++) begin
         for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 64; c++) begin
               logic [63:0] st, pc, sv, spc, ns, vec;
               logic flt, crit, ah;
               st = pats[p];
               pc = 64'h1000 + 64'(c) * 16;
               flt = (c == 2) || (c == 3) || (c == 5) || (c == 6) || (c == 7);
               crit = (m == 1) && ((c == 10) || (c == 11));
               ah = (alts[p] == 2'd3) && st[5] && st[4];
               sv = (m == 1) ? st : (st & ~RSV);
               spc = flt ? pc - 64'd4 : pc;
               ns = (c <= 1) ? 64'd0 : (st & 64'h1000);
               if (ah) ns = ns | 64'h30;
               vec = (64'(c) << 8) | PFX | (ah ? ALTV : 64'd0);
               go(1, 0, 6'(c), m[0], 0, pc, st, alts[p], 0, 0);
               chk("R12 ack_entry", {63'd0, ack_entry}, 64'd1);
               if (c == 63) begin
                  chk("R7 vec_err undefined", {63'd0, vec_err}, 64'd1);
                  chk_regs("R7 undefined no write");
               end else begin
                  chk("R7 vec_err clear", {63'd0, vec_err}, 64'd0);
                  if (crit) begin e_cp = spc; e_cs = sv; end
                  else begin e_sp = spc; e_ss = sv; end
                  e_so = ns; e_po = vec;
                  chk_regs("R2 R3 R4 R5 R7 R8 sweep");
               end
            end
         end
      end
      @(negedge clk);
      chk("R12 ack drops", {63'd0, ack_entry}, 64'd0);
      // R10 R11 classic 64-bit return
      go(1, 0, 6'd8, 0, 0, 64'h2003, pats[2], 0, 0, 0);
      chk("R2 save_st", save_st, 64'h8000_0000_0000_1030);
      go(0, 1, 6'd0, 0, 0, 0, 64'd0, 0, 0, 0);
      chk("R12 ack_ret", {63'd0, ack_ret}, 64'd1);
      chk("R10 ret pc", pc_out, 64'h2000);
      chk("R11 ret st wide", state_out, 64'h8000_0000_0000_1030);
      @(negedge clk);
      chk("R12 ack_ret drops", {63'd0, ack_ret}, 64'd0);
      // R11 32-bit keep-high variants
      go(1, 0, 6'd9, 0, 0, 64'h4000, 64'h0000_0000_FFFF_FFFF, 0, 0, 0);
      chk("R2 classic mask", save_st, 64'h0000_0000_87C0_FFFF);
      go(0, 1, 6'd0, 0, 0, 0, 64'hABCD_0000_0000_0000, 0, 0, 1);
      chk("R11 keep_high", state_out, 64'hABCD_0000_87C0_FFFF);
      chk("R10 ret pc2", pc_out, 64'h4000);
      go(0, 1, 6'd0, 0, 0, 0, 64'hABCD_0000_0000_0000, 0, 0, 0);
      chk("R11 no keep_high", state_out, 64'h0000_0000_87C0_FFFF);
      // R4 R10 R11 critical pair
      go(1, 0, 6'd10, 1, 0, 64'h3002, 64'h0000_0000_783F_0001, 0, 0, 0);
      chk("R4 crit_pc", crit_pc, 64'h3002);
      chk("R4 crit_st", crit_st, 64'h0000_0000_783F_0001);
      go(0, 1, 6'd0, 1, 0, 0, 64'd0, 0, 1, 0);
      chk("R10 crit ret pc", pc_out, 64'h3000);
      chk("R11 embedded mask", state_out, 64'h0000_0000_783F_0001);
      go(0, 1, 6'd0, 0, 0, 0, 64'd0, 0, 1, 0);
      chk("R11 classic mask on crit", state_out, 64'h0000_0000_0000_0001);
      // R12 simultaneous requests
      go(1, 1, 6'd8, 0, 0, 64'h5000, pats[1], 0, 0, 0);
      chk("R12 both entry", {63'd0, ack_entry}, 64'd1);
      chk("R12 both no ret", {63'd0, ack_ret}, 64'd0);
      chk("R12 both save_pc", save_pc, 64'h5000);
      e_sp = save_pc; e_ss = save_st; e_cp = crit_pc; e_cs = crit_st;
      e_so = state_out; e_po = pc_out;
      // R9 floating-point discard
      go(1, 0, 6'd6, 0, 1, 64'h6000, 64'h1900, 0, 0, 0);
      chk("R9 discard fp off", {63'd0, discard}, 64'd1);
      chk_regs("R9 fp off no write");
      go(1, 0, 6'd6, 0, 1, 64'h6000, 64'h3000, 0, 0, 0);
      chk("R9 discard modes off", {63'd0, discard}, 64'd1);
      chk_regs("R9 modes off no write");
      go(1, 0, 6'd6, 0, 1, 64'h6000, 64'h3100, 0, 0, 0);
      chk("R9 not discarded", {63'd0, discard}, 64'd0);
      chk("R9 taken save_pc", save_pc, 64'h5FFC);
      chk("R9 taken state", state_out, 64'h1000);
      e_sp = save_pc; e_ss = save_st; e_so = state_out; e_po = pc_out;
      // R6 R13 checkstop
      go(1, 0, 6'd1, 0, 0, 64'h7000, 64'h0, 0, 0, 0);
      chk("R6 checkstop set", {63'd0, checkstop}, 64'd1);
      chk("R6 ack", {63'd0, ack_entry}, 64'd1);
      chk_regs("R6 no write");
      go(1, 0, 6'd8, 0, 0, 64'h8000, pats[0], 0, 0, 0);
      chk("R13 no ack entry", {63'd0, ack_entry}, 64'd0);
      chk_regs("R13 entry ignored");
      go(0, 1, 6'd0, 0, 0, 0, 64'd0, 0, 0, 0);
      chk("R13 no ack ret", {63'd0, ack_ret}, 64'd0);
      chk_regs("R13 ret ignored");
      chk("R6 still set", {63'd0, checkstop}, 64'd1);
      // R1 reset clears checkstop and table
      do_reset();
      chk("R1 checkstop cleared", {63'd0, checkstop}, 64'd0);
      chk_regs("R1 second reset");
      go(1, 0, 6'd8, 0, 0, 64'h100, 64'h1000, 0, 0, 0);
      chk("R1 table reset", {63'd0, vec_err}, 64'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule